// File: doc/BRIEF.md
# CRC-CCITT Accumulator for a Custom-Instruction Port

This block sits beside a processor's ALU and is reached through a multi-cycle custom-instruction port. Each issue carries one 16-bit operand and a one-bit mode flag. With the flag set, the operand is written straight into an internal 16-bit CRC register, which is how software seeds a new checksum (0xFFFF for CRC-CCITT). With the flag clear, the operand is treated as the next 16 message bits and folded into that register. The register lives on between issues, so a message of any length is handled by one seeding issue followed by one issue per 16-bit word.

The fold divides by the polynomial 0x1021, most significant bit first. Four message bits are consumed per clock, so a data issue takes four cycles and a seeding issue takes one. Completion is signalled by a one-cycle `done` pulse, and the result port always shows the current register contents. The block touches no memory and no other peripheral.

Top module: `crc_ci_unit`

## Requirements
- R1: After reset, `result` is 0x0000 and both `done` and `busy` are 0.
- R2: A `start` with `init_mode`=1, accepted while idle, copies `operand` into the CRC register. `done` is 1 in the next cycle, with `result` equal to that operand and `busy` at 0.
- R3: A `start` with `init_mode`=0 folds `operand` into the CRC register bit by bit, from bit 15 down to bit 0. For each bit, feedback is register bit 15 XOR the message bit. The register shifts left by one, and if feedback is 1 it is XORed with 0x1021.
- R4: A data issue raises `busy` in the cycle after `start` is sampled. `done` appears exactly 4 cycles after `start` is sampled, and `busy` is 0 in that cycle.
- R5: `done` is high for one cycle per completed issue. It stays high for a second cycle only when a new seeding issue was accepted in the cycle it was first high.
- R6: A `start` that arrives while `busy` is 1 is ignored. The issue in progress completes on schedule with an unchanged result, whatever `init_mode` and `operand` were.
- R7: While no issue is running or being accepted, the CRC register and `result` hold their value.
- R8: Successive data issues accumulate. After a seed and N words, `result` equals the fold of those N words applied in order to the seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue strobe, accepted only while idle |
| init_mode | input | 1 | 1: seed the register, 0: fold the operand as message bits |
| operand | input | 16 | Seed value or message word |
| result | output | 16 | Current CRC register contents |
| done | output | 1 | One-cycle pulse when the issue's result is valid |
| busy | output | 1 | High while a data issue is in progress |

## Verification
Directed words with a single bit set at 15 or at 0 separate errors in the bit order from errors in the feedback tap. All-zero and all-ones words, folded into a zero seed and into the 0xFFFF seed, expose a missing polynomial XOR and a wrong feedback term. Long random chains with seeds placed at random points test whether state is carried between issues, and a mismatch there points to accumulation rather than to a single fold. Issue latency is counted on every call, and seeding strobes aimed at a running fold show whether a busy start leaks into the register.

// File: rtl/crc_ci_pkg.sv
package crc_ci_pkg;

  localparam int CRC_W = 16;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ci_state_e;

  // One message bit through the MSB-first division step.
  function automatic logic [CRC_W-1:0] crc_bit_step(
    input logic [CRC_W-1:0] cur,
    input logic             msg_bit,
    input logic [CRC_W-1:0] poly
  );
    logic fb;
    fb = cur[CRC_W-1] ^ msg_bit;
    return fb ? ((cur << 1) ^ poly) : (cur << 1);
  endfunction

endpackage

// File: rtl/crc_ci_chunk.sv
module crc_ci_chunk
  import crc_ci_pkg::*;
#(
  parameter int               BPC  = 4,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [BPC-1:0]   msg_bits,
  output logic [CRC_W-1:0] crc_out
);

  logic [CRC_W-1:0] stage [0:BPC];

  assign stage[0] = crc_in;

  // Highest message bit enters first.
  for (genvar g = 0; g < BPC; g++) begin : g_bit
    assign stage[g+1] = crc_bit_step(stage[g], msg_bits[BPC-1-g], POLY);
  end

  assign crc_out = stage[BPC];

endmodule

// File: rtl/crc_ci_ctrl.sv
module crc_ci_ctrl
  import crc_ci_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic init_mode,
  output logic load_init,
  output logic take_first,
  output logic take_next,
  output logic busy,
  output logic done
);

  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  ci_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             accept;
  logic             last_step;

  assign accept     = start && (state_q == ST_IDLE);
  assign load_init  = accept && init_mode;
  assign take_first = accept && !init_mode;
  assign take_next  = (state_q == ST_RUN);
  assign last_step  = (cnt_q == CNT_W'(STEPS - 1));
  assign busy       = (state_q == ST_RUN);
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (load_init) begin
            done_q <= 1'b1;
          end else if (take_first) begin
            state_q <= ST_RUN;
            cnt_q   <= CNT_W'(1);
          end
        end
        ST_RUN: begin
          if (last_step) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_init |=> (done && !busy)); // R2
  AST_DATA_ENTERS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    take_first |=> (busy && !done)); // R4
  AST_RUN_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_step) |=> (done && !busy)); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> (busy && !done)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> !done); // R5

endmodule

// File: rtl/crc_ci_datapath.sv
module crc_ci_datapath
  import crc_ci_pkg::*;
#(
  parameter int               BPC  = 4,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_init,
  input  logic             take_first,
  input  logic             take_next,
  input  logic [CRC_W-1:0] operand,
  output logic [CRC_W-1:0] result
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] sh_q;
  logic [BPC-1:0]   chunk_bits;
  logic [CRC_W-1:0] chunk_out;

  // The first slice comes straight from the operand, so no cycle is spent capturing it.
  assign chunk_bits = take_first ? operand[CRC_W-1 -: BPC] : sh_q[CRC_W-1 -: BPC];

  crc_ci_chunk #(
    .BPC  (BPC),
    .POLY (POLY)
  ) u_chunk (
    .crc_in   (crc_q),
    .msg_bits (chunk_bits),
    .crc_out  (chunk_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
      sh_q  <= '0;
    end else if (load_init) begin
      crc_q <= operand;
    end else if (take_first) begin
      crc_q <= chunk_out;
      sh_q  <= operand << BPC;
    end else if (take_next) begin
      crc_q <= chunk_out;
      sh_q  <= sh_q << BPC;
    end
  end

  assign result = crc_q;

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_init |=> (result == $past(operand))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_init || take_first || take_next) |=> $stable(result)); // R7
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_init, take_first, take_next})); // R6

endmodule

// File: rtl/crc_ci_unit.sv
module crc_ci_unit
  import crc_ci_pkg::*;
#(
  parameter int               BITS_PER_CYCLE = 4,
  parameter logic [CRC_W-1:0] POLY           = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             init_mode,
  input  logic [CRC_W-1:0] operand,
  output logic [CRC_W-1:0] result,
  output logic             done,
  output logic             busy
);

  // BITS_PER_CYCLE must divide CRC_W and be smaller than it.
  localparam int STEPS = CRC_W / BITS_PER_CYCLE;

  logic load_init;
  logic take_first;
  logic take_next;

  crc_ci_ctrl #(
    .STEPS (STEPS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .init_mode  (init_mode),
    .load_init  (load_init),
    .take_first (take_first),
    .take_next  (take_next),
    .busy       (busy),
    .done       (done)
  );

  crc_ci_datapath #(
    .BPC  (BITS_PER_CYCLE),
    .POLY (POLY)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_init  (load_init),
    .take_first (take_first),
    .take_next  (take_next),
    .operand    (operand),
    .result     (result)
  );

endmodule

// File: tb/crc_ci_unit_bench.sv
module crc_ci_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        init_mode = 1'b0;
  logic [15:0] operand = 16'h0;
  logic [15:0] result;
  logic        done;
  logic        busy;

  int total = 0;
  int bad = 0;
  logic [15:0] model = 16'h0;

  always #5 clk = ~clk;

  crc_ci_unit u_crc_ci_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .init_mode(init_mode),
    .operand(operand), .result(result), .done(done), .busy(busy)
  );

  // Word-wide division form: merge the whole word, then 16 shifts.
  function automatic logic [15:0] ref_fold(input logic [15:0] seed, input logic [15:0] word);
    logic [15:0] r;
    r = seed ^ word;
    for (int i = 0; i < 16; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one call; returns cycles from start sample to done.
  task automatic issue(input logic mode, input logic [15:0] val, output int lat);
    @(negedge clk);
    start = 1'b1; init_mode = mode; operand = val;
    @(negedge clk);
    start = 1'b0; operand = $urandom();
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_init(input logic [15:0] val);
    int lat;
    issue(1'b1, val, lat);
    model = val;
    check("R2 seed value", {16'h0, result}, {16'h0, val});
    check("R2 seed latency", lat, 1);
    check("R2 not busy", {31'h0, busy}, 0);
  endtask

  task automatic do_data(input logic [15:0] val, input string req);
    int lat;
    issue(1'b0, val, lat);
    model = ref_fold(model, val);
    check(req, {16'h0, result}, {16'h0, model});
    check("R4 data latency", lat, 4);
    check("R4 busy low at done", {31'h0, busy}, 0);
  endtask

  initial begin
    int lat;
    logic [15:0] held;
    void'($urandom(32'h5EED1021));
    repeat (3) @(negedge clk);
    check("R1 reset result", {16'h0, result}, 0);
    check("R1 reset done", {31'h0, done}, 0);
    check("R1 reset busy", {31'h0, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 result after release", {16'h0, result}, 0);

    // Directed corners, R3.
    do_init(16'hFFFF);
    do_data(16'h0000, "R3 zero word on FFFF");
    do_init(16'hFFFF);
    do_data(16'hFFFF, "R3 ones word on FFFF");
    do_init(16'h0000);
    do_data(16'h8000, "R3 bit15 only");
    do_init(16'h0000);
    do_data(16'h0001, "R3 bit0 only");
    do_init(16'h0000);
    do_data(16'h0000, "R3 zero stays zero");

    // R5: one-cycle pulse after a data call.
    do_init(16'hFFFF);
    do_data(16'h1234, "R8 chain word 1");
    @(negedge clk);
    check("R5 done drops", {31'h0, done}, 0);

    // R7: holds while idle.
    held = result;
    repeat (6) @(negedge clk);
    check("R7 idle hold", {16'h0, result}, {16'h0, held});
    do_data(16'hABCD, "R8 chain word 2 after idle");

    // R6: seeding strobe during a running fold is ignored.
    @(negedge clk);
    start = 1'b1; init_mode = 1'b0; operand = 16'h5A5A;
    @(negedge clk);
    init_mode = 1'b1; operand = 16'h1234;   // still start=1 while busy
    check("R6 busy during fold", {31'h0, busy}, 1);
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    model = ref_fold(model, 16'h5A5A);
    check("R6 result unaffected", {16'h0, result}, {16'h0, model});
    check("R6 latency unaffected", lat, 4);
    @(negedge clk);
    check("R6 no extra done", {31'h0, done}, 0);
    check("R6 register kept", {16'h0, result}, {16'h0, model});

    // Random chains, R8.
    for (int n = 0; n < 60; n++) begin
      if (($urandom() % 6) == 0) do_init(16'($urandom()));
      else do_data(16'($urandom()), "R8 random chain");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R4 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule